// File: doc/BRIEF.md
# Single-Bus Multi-Cycle Datapath

This block is the datapath half of a microprogrammed processor. One 32-bit shared bus connects every storage element. On each clock a controller presents a word of control points. These choose one source to drive the bus and the destinations that capture it at the next edge. Sources are the register file, memory read data, the ALU result and the immediate extender. Destinations are the memory address latch, the two ALU operand latches, the instruction register, the register file and memory.

The register file holds the 32 architectural registers plus one extra slot for the program counter. A small select code picks the entry to access: a field of the instruction register, the PC slot, or the link register. The block reports three things back to the controller: whether operand A is zero, the opcode field of the instruction register, and the busy signal from memory. Memory is slow. While a read is in progress, no destination captures the bus, so the controller can simply repeat the same control word until busy drops.

Top module: `ubus_datapath`

## Requirements
- R1: The bus value (`bus_val`) is the source whose enable is set: register file (`en_reg`), memory read data (`en_mem`), ALU (`en_alu`), immediate (`en_imm`). With no enable set the bus is zero. At most one enable may be set in any cycle.
- R2: At a clock edge, each of `ld_ma`, `ld_a`, `ld_b` and `ld_ir` copies the bus into its own latch. A latch whose strobe is low keeps its value.
- R3: `reg_sel` picks the register index. The codes are: 0 = IR[25:21], 1 = IR[20:16], 2 = IR[15:11], 3 = PC slot (index 32), 4 = link register (index 31). Codes 5 to 7 select index 0.
- R4: Index 0 always reads as zero, and a write to index 0 leaves every register unchanged.
- R5: With `reg_wr` high, the selected entry takes the bus value at the clock edge. The entry can then be read back through any select code that resolves to the same index.
- R6: `ext_sel` shapes IR[15:0]. The codes are: 0 = sign extension, 1 = zero extension, 2 = sign extension of the field shifted left by two. Code 3 gives zero.
- R7: `alu_op` combines A and B as follows: 0 add, 1 A-B, 2 and, 3 or, 4 xor, 5 signed A<B giving 1 or 0, 6 B, 7 A+4.
- R8: `alu_op` 8 gives the jump target: A[31:28], then B[25:0], then two zero bits. Codes 9 to 15 give zero.
- R9: `st_zero` is high exactly when latch A holds zero. `st_opcode` is IR[31:26].
- R10: `mem_req` = `en_mem` or `mem_wr`. `mem_we` = `mem_wr`. `mem_addr` is the address latch with bits 1:0 forced to zero. `mem_wdata` is the bus.
- R11: While `en_mem` and `mem_busy` are both high, no load strobe and no register write takes effect.
- R12: After reset, every latch and every register, the PC slot included, holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_reg | input | 1 | Register file drives the bus |
| en_mem | input | 1 | Memory read data drives the bus |
| en_alu | input | 1 | ALU result drives the bus |
| en_imm | input | 1 | Extended immediate drives the bus |
| ld_ma | input | 1 | Capture the bus into the address latch |
| ld_a | input | 1 | Capture the bus into operand A |
| ld_b | input | 1 | Capture the bus into operand B |
| ld_ir | input | 1 | Capture the bus into the instruction register |
| reg_wr | input | 1 | Write the bus into the selected register |
| mem_wr | input | 1 | Request a memory write of the bus |
| reg_sel | input | 3 | Register index select code |
| ext_sel | input | 2 | Immediate extension mode |
| alu_op | input | 4 | ALU operation code |
| st_zero | output | 1 | Operand A equals zero |
| st_busy | output | 1 | Memory busy, passed through |
| st_opcode | output | 6 | Opcode field of the instruction register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_busy | input | 1 | Memory access still in progress |
| bus_val | output | 32 | Current value on the shared bus |

## Verification
The properties assume that the controller never sets more than one bus enable in a cycle. They also assume that memory holds `mem_busy` only while a request is active. The stimulus drives every control word through a single task that selects exactly one source, and it repeats a memory control word unchanged until busy drops. The bench memory model raises busy for a fixed number of cycles at the start of each request. Because of that, the stall window is always entered with a stable address latch, and the hold property sees real busy cycles.

// File: rtl/ubus_pkg.sv
package ubus_pkg;
    localparam int unsigned INSN_W = 32;

    typedef enum logic [2:0] {
        SEL_RS   = 3'd0,
        SEL_RT   = 3'd1,
        SEL_RD   = 3'd2,
        SEL_PC   = 3'd3,
        SEL_LINK = 3'd4
    } rsel_e;

    typedef enum logic [1:0] {
        EXT_SIGN = 2'd0,
        EXT_ZERO = 2'd1,
        EXT_BR   = 2'd2
    } ext_e;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_PASB = 4'd6,
        OP_INC4 = 4'd7,
        OP_JTGT = 4'd8
    } aop_e;
endpackage

// File: rtl/ubus_immext.sv
module ubus_immext #(
    parameter int unsigned W = 32
) (
    input  logic [15:0]  imm,
    input  logic [1:0]   sel,
    output logic [W-1:0] val
);
    import ubus_pkg::*;

    always_comb begin
        unique case (sel)
            EXT_SIGN: val = {{(W-16){imm[15]}}, imm};
            EXT_ZERO: val = {{(W-16){1'b0}}, imm};
            EXT_BR:   val = {{(W-18){imm[15]}}, imm, 2'b00};
            default:  val = '0;
        endcase
    end
endmodule

// File: rtl/ubus_alu.sv
module ubus_alu #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op,
    output logic [W-1:0] y
);
    import ubus_pkg::*;

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLT:  y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            OP_PASB: y = b;
            OP_INC4: y = a + W'(4);
            OP_JTGT: y = {a[W-1:W-4], b[W-7:0], 2'b00};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/ubus_regfile.sv
module ubus_regfile #(
    parameter int unsigned W     = 32,
    parameter int unsigned NARCH = 32,
    localparam int unsigned NENT = NARCH + 1,
    localparam int unsigned IW   = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] rf_q [NENT];
    logic [W-1:0] rf_d [NENT];

    always_comb begin
        rf_d = rf_q;
        if (wr_en && idx != '0 && 32'(idx) < NENT) begin
            rf_d[idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) rf_q[i] <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rd_data = (idx == '0 || 32'(idx) >= NENT) ? '0 : rf_q[idx];
endmodule

// File: rtl/ubus_datapath.sv
module ubus_datapath
    import ubus_pkg::*;
#(
    parameter int unsigned W        = 32,
    parameter int unsigned NARCH    = 32,
    parameter int unsigned LINK_IDX = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_reg,
    input  logic         en_mem,
    input  logic         en_alu,
    input  logic         en_imm,
    input  logic         ld_ma,
    input  logic         ld_a,
    input  logic         ld_b,
    input  logic         ld_ir,
    input  logic         reg_wr,
    input  logic         mem_wr,
    input  logic [2:0]   reg_sel,
    input  logic [1:0]   ext_sel,
    input  logic [3:0]   alu_op,
    output logic         st_zero,
    output logic         st_busy,
    output logic [5:0]   st_opcode,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_busy,
    output logic [W-1:0] bus_val
);
    localparam int unsigned IW     = $clog2(NARCH + 1);
    localparam int unsigned PC_IDX = NARCH;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] ma;
        logic [W-1:0] ir;
    } dp_t;

    dp_t st_d, st_q;

    logic [IW-1:0] rf_idx;
    logic [W-1:0]  rf_rd, imm_val, alu_y;
    logic          take;
    logic [W-1:0]  a_cur;

    always_comb begin
        unique case (reg_sel)
            SEL_RS:   rf_idx = IW'(st_q.ir[25:21]);
            SEL_RT:   rf_idx = IW'(st_q.ir[20:16]);
            SEL_RD:   rf_idx = IW'(st_q.ir[15:11]);
            SEL_PC:   rf_idx = IW'(PC_IDX);
            SEL_LINK: rf_idx = IW'(LINK_IDX);
            default:  rf_idx = '0;
        endcase
    end

    assign take = !(en_mem && mem_busy);

    ubus_regfile #(.W(W), .NARCH(NARCH)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (rf_idx),
        .wr_en   (reg_wr && take),
        .wr_data (bus_val),
        .rd_data (rf_rd)
    );

    ubus_immext #(.W(W)) u_ext (
        .imm (st_q.ir[15:0]),
        .sel (ext_sel),
        .val (imm_val)
    );

    ubus_alu #(.W(W)) u_alu (
        .a  (st_q.a),
        .b  (st_q.b),
        .op (alu_op),
        .y  (alu_y)
    );

    // Wired-OR merge of gated sources, standing in for tri-state drivers.
    assign bus_val = (en_reg ? rf_rd     : '0)
                   | (en_mem ? mem_rdata : '0)
                   | (en_alu ? alu_y     : '0)
                   | (en_imm ? imm_val   : '0);

    always_comb begin
        st_d = st_q;
        if (take) begin
            if (ld_a)  st_d.a  = bus_val;
            if (ld_b)  st_d.b  = bus_val;
            if (ld_ma) st_d.ma = bus_val;
            if (ld_ir) st_d.ir = bus_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_cur     = st_q.a;
    assign st_zero   = (st_q.a == '0);
    assign st_busy   = mem_busy;
    assign st_opcode = st_q.ir[31:26];
    assign mem_req   = en_mem | mem_wr;
    assign mem_we    = mem_wr;
    assign mem_addr  = {st_q.ma[W-1:2], 2'b00};
    assign mem_wdata = bus_val;
endmodule

// File: rtl/ubus_datapath_chk.sv
module ubus_datapath_chk #(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_reg,
    input logic          en_mem,
    input logic          en_alu,
    input logic          en_imm,
    input logic          ld_ma,
    input logic          ld_a,
    input logic          ld_ir,
    input logic          mem_busy,
    input logic          st_zero,
    input logic [5:0]    st_opcode,
    input logic [W-1:0]  mem_addr,
    input logic [W-1:0]  bus_val,
    input logic [IW-1:0] rf_idx
);
    logic stall;
    assign stall = en_mem && mem_busy;

    p_single_driver_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({en_reg, en_mem, en_alu, en_imm}) <= 1);

    p_capture_ma_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ma && !stall) |=> (mem_addr == {$past(bus_val[W-1:2]), 2'b00}));

    p_reg0_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_reg && !en_mem && !en_alu && !en_imm && rf_idx == '0) |-> (bus_val == '0));

    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a && !stall) |=> (st_zero == ($past(bus_val) == '0)));

    p_ir_opcode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ir && !stall) |=> (st_opcode == $past(bus_val[31:26])));

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(mem_addr) && $stable(st_opcode) && $stable(st_zero)));
endmodule

bind ubus_datapath ubus_datapath_chk #(.W(W), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_reg    (en_reg),
    .en_mem    (en_mem),
    .en_alu    (en_alu),
    .en_imm    (en_imm),
    .ld_ma     (ld_ma),
    .ld_a      (ld_a),
    .ld_ir     (ld_ir),
    .mem_busy  (mem_busy),
    .st_zero   (st_zero),
    .st_opcode (st_opcode),
    .mem_addr  (mem_addr),
    .bus_val   (bus_val),
    .rf_idx    (rf_idx)
);

// File: tb/ubus_datapath_tb.sv
module ubus_datapath_tb;
    localparam int CLK_P = 10;
    localparam int LAT   = 2;

    logic clk = 0, rst_n = 0;
    logic en_reg = 0, en_mem = 0, en_alu = 0, en_imm = 0;
    logic ld_ma = 0, ld_a = 0, ld_b = 0, ld_ir = 0, reg_wr = 0, mem_wr = 0;
    logic [2:0] reg_sel = 0;
    logic [1:0] ext_sel = 0;
    logic [3:0] alu_op = 0;
    logic st_zero, st_busy, mem_req, mem_we, mem_busy;
    logic [5:0] st_opcode;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, bus_val;

    int errors = 0, checks = 0, wp = 0, rp = 0;
    logic [31:0] img [256];
    logic [31:0] mem [256];
    int cnt;

    always #(CLK_P/2) clk = ~clk;

    ubus_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .en_reg(en_reg), .en_mem(en_mem), .en_alu(en_alu),
        .en_imm(en_imm), .ld_ma(ld_ma), .ld_a(ld_a), .ld_b(ld_b), .ld_ir(ld_ir),
        .reg_wr(reg_wr), .mem_wr(mem_wr), .reg_sel(reg_sel), .ext_sel(ext_sel),
        .alu_op(alu_op), .st_zero(st_zero), .st_busy(st_busy), .st_opcode(st_opcode),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_busy(mem_busy), .bus_val(bus_val)
    );

    // Slow memory model: busy for LAT cycles at the start of each request.
    assign mem_busy  = mem_req && (cnt < LAT);
    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= img[i];
        end else begin
            if (mem_req && cnt < LAT) cnt <= cnt + 1;
            else                      cnt <= 0;
            if (mem_req && mem_we && !mem_busy) mem[mem_addr[9:2]] <= mem_wdata;
        end
    end

    function automatic logic [31:0] val(input int k);
        if (k == 5) return 32'h0;
        return (32'(k) * 32'h9E3779B9) ^ (32'(k) << 27);
    endfunction

    function automatic logic [31:0] alu_ref(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6: return b;
            7: return a + 32'd4;
            8: return {a[31:28], b[25:0], 2'b00};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        {en_reg, en_mem, en_alu, en_imm} = 4'b0;
        {ld_ma, ld_a, ld_b, ld_ir, reg_wr, mem_wr} = 6'b0;
        reg_sel = 0; ext_sel = 0; alu_op = 0;
    endtask

    // src: 0 reg, 1 mem, 2 alu, 3 imm, 4 none; dm = {ld_ma,ld_a,ld_b,ld_ir,reg_wr,mem_wr}
    task automatic drive(input int src, input int rs, input int es, input int op, input logic [5:0] dm);
        idle();
        en_reg = (src == 0); en_mem = (src == 1); en_alu = (src == 2); en_imm = (src == 3);
        reg_sel = 3'(rs); ext_sel = 2'(es); alu_op = 4'(op);
        {ld_ma, ld_a, ld_b, ld_ir, reg_wr, mem_wr} = dm;
    endtask

    task automatic step(input int src, input int rs, input int es, input int op, input logic [5:0] dm);
        drive(src, rs, es, op, dm);
        #1;
        while (mem_busy) begin @(posedge clk); @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        idle();
    endtask

    function automatic logic [31:0] peek(input int src, input int rs, input int es, input int op);
        return 32'h0;
    endfunction

    task automatic look(input int src, input int rs, input int es, input int op, output logic [31:0] v);
        drive(src, rs, es, op, 6'b0);
        #1; v = bus_val;
        idle();
    endtask

    // Stream the next memory word into a destination and advance the PC slot.
    task automatic stream(input logic to_ir, input int rsel);
        step(0, 3, 0, 0, 6'b110000);                                   // MA,A <- PC
        if (to_ir) step(1, 0, 0, 0, 6'b000100);                        // IR <- mem
        else       step(1, rsel, 0, 0, 6'b000010);                     // reg <- mem
        step(2, 3, 0, 7, 6'b000010);                                   // PC <- A+4
        rp++;
    endtask

    function automatic void push(input logic [31:0] w);
        img[wp] = w; wp++;
    endfunction

    logic [15:0] pats [6] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'h8004};
    int pa [7] = '{1, 3, 5, 0, 9, 31, 12};
    int pb [7] = '{2, 4, 0, 7, 9, 17, 20};

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 256; i++) img[i] = 32'hDEAD_0000 | 32'(i);
        for (int i = 0; i < 6; i++) push({6'(i + 1), 5'(i), 5'(i + 1), pats[i]});
        for (int k = 0; k < 32; k++) begin
            push({6'h0A, 5'(k), 5'(k), 5'(k), 11'h0});
            push(val(k));
        end
        for (int p = 0; p < 7; p++) push({6'h11, 5'(pa[p]), 5'(pb[p]), 16'h0});
        push({6'h2B, 5'd0, 5'd3, 16'h0203});

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R12: reset state
        chk("R12 opcode", 32'(st_opcode), 0);
        chk("R12 zero", 32'(st_zero), 1);
        chk("R12 addr", mem_addr, 0);
        look(0, 3, 0, 0, v); chk("R12 pc", v, 0);
        look(4, 0, 0, 0, v); chk("R1 no driver", v, 0);

        // R6: immediate extension sweep, R9 opcode
        for (int i = 0; i < 6; i++) begin
            stream(1, 0);
            chk("R9 opcode", 32'(st_opcode), 32'(i + 1));
            look(3, 0, 0, 0, v); chk("R6 sext", v, {{16{pats[i][15]}}, pats[i]});
            look(3, 0, 1, 0, v); chk("R6 zext", v, {16'h0, pats[i]});
            look(3, 0, 2, 0, v); chk("R6 branch", v, {{14{pats[i][15]}}, pats[i], 2'b00});
            look(3, 0, 3, 0, v); chk("R6 code3", v, 0);
        end

        // R3/R4/R5: write and read back every register through three selects
        for (int k = 0; k < 32; k++) begin
            stream(1, 0);
            stream(0, 2);
            look(0, 2, 0, 0, v); chk("R5 rd read", v, (k == 0) ? 32'h0 : val(k));
            look(0, 0, 0, 0, v); chk("R3 rs read", v, (k == 0) ? 32'h0 : val(k));
            look(0, 1, 0, 0, v); chk("R4 rt read", v, (k == 0) ? 32'h0 : val(k));
        end
        look(0, 4, 0, 0, v); chk("R3 link", v, val(31));
        look(0, 3, 0, 0, v); chk("R3 pc", v, 32'(rp * 4));
        for (int c = 5; c < 8; c++) begin
            look(0, c, 0, 0, v); chk("R3 unused code", v, 0);
        end

        // R2/R7/R8/R9: ALU sweep over operand pairs
        for (int p = 0; p < 7; p++) begin
            stream(1, 0);
            step(0, 0, 0, 0, 6'b010000);                               // A <- Reg[rs]
            step(0, 1, 0, 0, 6'b001000);                               // B <- Reg[rt]
            chk("R9 zero flag", 32'(st_zero), (val(pa[p]) == 0 || pa[p] == 0) ? 1 : 0);
            for (int op = 0; op < 10; op++) begin
                look(2, 0, 0, op, v);
                chk(op == 8 ? "R8 jump target" : "R7 alu op", v,
                    alu_ref(op, pa[p] == 0 ? 32'h0 : val(pa[p]), pb[p] == 0 ? 32'h0 : val(pb[p])));
            end
        end

        // R10: store path
        stream(1, 0);
        step(3, 0, 1, 0, 6'b100000);                                   // MA <- zext imm
        chk("R10 addr aligned", mem_addr, 32'h200);
        drive(0, 1, 0, 0, 6'b000001); #1;
        chk("R10 req", 32'(mem_req), 1);
        chk("R10 we", 32'(mem_we), 1);
        chk("R10 wdata", mem_wdata, val(3));
        while (mem_busy) begin @(posedge clk); @(negedge clk); #1; end
        @(posedge clk); @(negedge clk); idle();
        chk("R10 stored word", mem[128], val(3));

        // R11: address latch held while memory is busy
        drive(1, 0, 0, 0, 6'b100000); #1;
        while (mem_busy) begin
            @(posedge clk); @(negedge clk); #1;
            chk("R11 hold", mem_addr, 32'h200);
        end
        @(posedge clk); @(negedge clk); idle();
        chk("R11 release", mem_addr, {val(3)[31:2], 2'b00});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule